// File: doc/BRIEF.md
# Paired Operand Read Sequencer

This block sits in the decode stage. It gathers the source operands of an accelerator subgraph when the register file can serve only two reads per cycle. A start pulse supplies a packed list of source register numbers and an operand count. The sequencer captures both. From the next cycle on, it reads the list two entries at a time through the two read ports, using one read cycle per pair. Each returned value goes out to the accelerator in the same cycle it is read. Operands are never collected into one wide transfer.

Each output beat has two data lanes, a valid bit for each lane, and the slot index of the first lane. The accelerator uses these to place every operand. The sequencer holds the fetch unit with a stall while more read cycles are still to come. It pulses done in the cycle that presents the final operands. A request with no operands does no reads and raises no stall. It pulses done alone in the cycle after the start.

Top module: `operand_read_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, beat valid, both lane valids, both read enables, fetch stall and done are all low.
- R2: The block reads at most two registers per cycle. In a read cycle, lane 0 reads slot index `slot_o` and lane 1 reads slot `slot_o + 1`. `slot_o` starts at 0 and rises by 2 on each following read cycle, so it is always even.
- R3: A request with N operands (N ≥ 1) produces exactly ceil(N/2) consecutive read cycles. The first is the cycle right after the start cycle. Beat valid is low after the last one.
- R4: Fetch stall is high in every read cycle except the last one of a request, and low in every other cycle.
- R5: The register number for slot k is taken from bits `[k*REG_AW +: REG_AW]` of the list. In the same cycle, each valid lane's data output equals the data on its own read port.
- R6: When N is odd, lane 1 of the last beat is invalid: its lane valid and read enable are low and its data output is zero.
- R7: Done is high for exactly one cycle, the final read cycle of the request.
- R8: A request with N = 0 gives done high in the cycle after the start and no beat and no stall. The cycle after that is idle.
- R9: A start pulse that arrives during a read cycle is ignored and does not change the running sequence.
- R10: A count above MAX_OPS is treated as MAX_OPS.
- R11: The list and count are captured in the start cycle. Changes on those inputs afterwards have no effect on the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when not in a read cycle |
| src_list_i | input | MAX_OPS*REG_AW | Packed source register numbers, slot 0 in the low bits |
| op_count_i | input | CNT_W | Number of operands |
| rd_en_a_o | output | 1 | Read port 0 enable |
| rd_addr_a_o | output | REG_AW | Read port 0 register number |
| rd_data_a_i | input | DATA_W | Read port 0 data, same cycle |
| rd_en_b_o | output | 1 | Read port 1 enable |
| rd_addr_b_o | output | REG_AW | Read port 1 register number |
| rd_data_b_i | input | DATA_W | Read port 1 data, same cycle |
| beat_valid_o | output | 1 | Operand beat present |
| lane_vld_o | output | 2 | Per-lane valid (bit 0 = lane 0) |
| slot_o | output | SLOT_W | Slot index of lane 0 |
| lane0_data_o | output | DATA_W | Operand in slot `slot_o` |
| lane1_data_o | output | DATA_W | Operand in slot `slot_o + 1` |
| fetch_stall_o | output | 1 | Hold fetch: more read cycles follow |
| done_o | output | 1 | Operand collection finished |

## Verification
The bench targets counts around the pair boundary (1, 2, 7, 8) and counts above the maximum. A design that miscounts would add or drop a beat, drive a phantom lane 1, or keep fetch stalled in the last cycle. Zero-count requests, including two in a row, catch a design that emits a stray beat or never raises done. Start pulses injected in mid-sequence show whether the design restarts or corrupts its slot index. Rewriting the list and count right after a start shows whether the design reads its inputs live instead of from a captured copy.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EMPTY = 2'd2
    } seq_state_e;

    // Control for the read cycle in progress
    typedef struct packed {
        logic active;   // a read cycle is in progress
        logic last;     // final read cycle of the request
        logic pair;     // lane 1 carries a real operand
    } step_t;

    // Limit a requested count to the supported maximum
    function automatic int unsigned clamp_count(input int unsigned req, input int unsigned max_ops);
        return (req > max_ops) ? max_ops : req;
    endfunction

endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
    import opseq_pkg::*;
#(
    parameter int MAX_OPS = 8,
    parameter int CNT_W   = $clog2(MAX_OPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             load_o,
    output logic [CNT_W-1:0] base_o,
    output step_t            step_o,
    output logic             stall_o,
    output logic             done_o
);
    localparam int EW = CNT_W + 1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] base_q, base_d;
    logic [CNT_W-1:0] total_q, total_d;
    logic [CNT_W-1:0] eff_count;
    logic [EW-1:0]    next_b, after_pair;
    logic             accept, pair, last;

    always_comb begin
        eff_count  = CNT_W'(clamp_count(int'(count_i), MAX_OPS));
        accept     = start_i && (state_q != ST_READ);
        next_b     = {1'b0, base_q} + EW'(1);
        after_pair = {1'b0, base_q} + EW'(2);
        pair       = next_b < {1'b0, total_q};
        last       = after_pair >= {1'b0, total_q};
    end

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        total_d = total_q;
        case (state_q)
            ST_READ: begin
                if (last) state_d = ST_IDLE;
                else      base_d  = after_pair[CNT_W-1:0];
            end
            default: begin
                state_d = ST_IDLE;
                if (accept) begin
                    base_d  = '0;
                    total_d = eff_count;
                    state_d = (eff_count == '0) ? ST_EMPTY : ST_READ;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            total_q <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            total_q <= total_d;
        end
    end

    always_comb begin
        load_o        = accept;
        base_o        = base_q;
        step_o.active = (state_q == ST_READ);
        step_o.last   = (state_q == ST_READ) && last;
        step_o.pair   = (state_q == ST_READ) && pair;
        stall_o       = (state_q == ST_READ) && !last;
        done_o        = ((state_q == ST_READ) && last) || (state_q == ST_EMPTY);
    end

    // R4
    stall_next_read_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (state_q == ST_READ));

    // R2
    base_step_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (base_q == $past(base_q) + CNT_W'(2)));

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && count_i == '0 && state_q != ST_READ) |=> (done_o && !stall_o && !step_o.active));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && stall_o) |=> (base_q != '0));

endmodule

// File: rtl/opseq_list.sv
module opseq_list
    import opseq_pkg::*;
#(
    parameter int MAX_OPS = 8,
    parameter int REG_AW  = 5,
    parameter int CNT_W   = $clog2(MAX_OPS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [MAX_OPS*REG_AW-1:0]   list_i,
    input  logic [CNT_W-1:0]            base_i,
    output logic [LANES-1:0][REG_AW-1:0] addr_o
);
    localparam int IW = CNT_W + 1;

    logic [MAX_OPS-1:0][REG_AW-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst)         regs_q <= '0;
        else if (load_i) regs_q <= list_i;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IW-1:0] idx;
        always_comb begin
            idx       = {1'b0, base_i} + IW'(l);
            addr_o[l] = '0;
            for (int k = 0; k < MAX_OPS; k++) begin
                if (idx == IW'(k)) addr_o[l] = regs_q[k];
            end
        end
    end

endmodule

// File: rtl/opseq_beat.sv
module opseq_beat
    import opseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  step_t                        step_i,
    input  logic [CNT_W-1:0]             base_i,
    input  logic [LANES-1:0][DATA_W-1:0] rd_data_i,
    output logic [LANES-1:0]             rd_en_o,
    output logic                         beat_valid_o,
    output logic [LANES-1:0]             lane_vld_o,
    output logic [SLOT_W-1:0]            slot_o,
    output logic [LANES-1:0][DATA_W-1:0] data_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic live;
        assign live = (l == 0) ? step_i.active : step_i.pair;
        always_comb begin
            rd_en_o[l]    = live;
            lane_vld_o[l] = live;
            data_o[l]     = live ? rd_data_i[l] : '0;
        end
    end

    assign beat_valid_o = step_i.active;
    assign slot_o       = step_i.active ? base_i[SLOT_W-1:0] : '0;

    // R6
    lane_order_chk: assert property (@(posedge clk) disable iff (rst)
        lane_vld_o[1] |-> (lane_vld_o[0] && beat_valid_o));

    // R2
    slot_even_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o |-> (slot_o[0] == 1'b0));

    // R6
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lane_vld_o[1] |-> (data_o[1] == '0 && !rd_en_o[1]));

endmodule

// File: rtl/operand_read_seq.sv
module operand_read_seq
    import opseq_pkg::*;
#(
    parameter int MAX_OPS = 8,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = $clog2(MAX_OPS + 1),
    parameter int SLOT_W  = $clog2(MAX_OPS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [MAX_OPS*REG_AW-1:0] src_list_i,
    input  logic [CNT_W-1:0]          op_count_i,
    output logic                      rd_en_a_o,
    output logic [REG_AW-1:0]         rd_addr_a_o,
    input  logic [DATA_W-1:0]         rd_data_a_i,
    output logic                      rd_en_b_o,
    output logic [REG_AW-1:0]         rd_addr_b_o,
    input  logic [DATA_W-1:0]         rd_data_b_i,
    output logic                      beat_valid_o,
    output logic [1:0]                lane_vld_o,
    output logic [SLOT_W-1:0]         slot_o,
    output logic [DATA_W-1:0]         lane0_data_o,
    output logic [DATA_W-1:0]         lane1_data_o,
    output logic                      fetch_stall_o,
    output logic                      done_o
);
    logic                         load;
    logic [CNT_W-1:0]             base;
    step_t                        step;
    logic [LANES-1:0][REG_AW-1:0] addr;
    logic [LANES-1:0][DATA_W-1:0] rdata, odata;
    logic [LANES-1:0]             rden;

    opseq_ctrl #(.MAX_OPS(MAX_OPS), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .count_i(op_count_i),
        .load_o(load), .base_o(base), .step_o(step),
        .stall_o(fetch_stall_o), .done_o(done_o)
    );

    opseq_list #(.MAX_OPS(MAX_OPS), .REG_AW(REG_AW), .CNT_W(CNT_W)) u_list (
        .clk(clk), .rst(rst), .load_i(load), .list_i(src_list_i),
        .base_i(base), .addr_o(addr)
    );

    assign rdata = {rd_data_b_i, rd_data_a_i};

    opseq_beat #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_beat (
        .clk(clk), .rst(rst), .step_i(step), .base_i(base), .rd_data_i(rdata),
        .rd_en_o(rden), .beat_valid_o(beat_valid_o), .lane_vld_o(lane_vld_o),
        .slot_o(slot_o), .data_o(odata)
    );

    assign rd_en_a_o    = rden[0];
    assign rd_en_b_o    = rden[1];
    assign rd_addr_a_o  = addr[0];
    assign rd_addr_b_o  = addr[1];
    assign lane0_data_o = odata[0];
    assign lane1_data_o = odata[1];

    // R7
    done_at_last_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !fetch_stall_o) |-> done_o);

    // R4
    stall_has_beat_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall_o |-> (beat_valid_o && lane_vld_o == 2'b11));

endmodule

// File: tb/sim_operand_read_seq.sv
module sim_operand_read_seq;
    localparam int MAXN = 8;
    localparam int AW   = 5;
    localparam int DW   = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic              start_i = 1'b0;
    logic [MAXN*AW-1:0] list_i = '0;
    logic [3:0]        count_i = '0;
    logic              en_a, en_b, bvalid, stall, done;
    logic [AW-1:0]     addr_a, addr_b;
    logic [DW-1:0]     data_a, data_b, l0, l1;
    logic [1:0]        lvld;
    logic [2:0]        slot;

    operand_read_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .src_list_i(list_i), .op_count_i(count_i),
        .rd_en_a_o(en_a), .rd_addr_a_o(addr_a), .rd_data_a_i(data_a),
        .rd_en_b_o(en_b), .rd_addr_b_o(addr_b), .rd_data_b_i(data_b),
        .beat_valid_o(bvalid), .lane_vld_o(lvld), .slot_o(slot),
        .lane0_data_o(l0), .lane1_data_o(l1), .fetch_stall_o(stall), .done_o(done)
    );

    function automatic logic [DW-1:0] rf(input logic [AW-1:0] a);
        return 32'h9E3779B9 * ({27'd0, a} + 32'd1);
    endfunction

    assign data_a = rf(addr_a);
    assign data_b = rf(addr_b);

    int ncmp = 0;
    int nbad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, {63'd0, bvalid}, 64'd0);
        chk(req, {63'd0, stall}, 64'd0);
        chk(req, {63'd0, done}, 64'd0);
    endtask

    task automatic run_req(input logic [MAXN*AW-1:0] l, input int cnt, input int inject);
        int n  = (cnt > MAXN) ? MAXN : cnt;
        int nb = (n + 1) / 2;
        @(negedge clk);
        start_i = 1'b1; list_i = l; count_i = cnt[3:0];
        @(negedge clk);
        start_i = 1'b0;
        list_i  = {$urandom, $urandom};   // R11: scramble after capture
        count_i = 4'($urandom);
        if (nb == 0) begin
            chk("R8 done", {63'd0, done}, 64'd1);
            chk("R8 beat", {63'd0, bvalid}, 64'd0);
            chk("R8 stall", {63'd0, stall}, 64'd0);
            start_i = 1'b0;
            @(negedge clk);
            check_idle("R8 after");
        end else begin
            for (int i = 0; i < nb; i++) begin
                logic lane_b;
                lane_b = (2*i + 1) < n;
                chk("R3 beat", {63'd0, bvalid}, 64'd1);
                chk("R2 slot", {61'd0, slot}, 64'(2*i));
                chk("R5 addr_a", {59'd0, addr_a}, 64'(l[2*i*AW +: AW]));
                chk("R5 lane0", {32'd0, l0}, {32'd0, rf(l[2*i*AW +: AW])});
                chk("R6 lane_vld", {62'd0, lvld}, {62'd0, lane_b, 1'b1});
                chk("R6 rd_en_b", {63'd0, en_b}, {63'd0, lane_b});
                if (lane_b) begin
                    chk("R5 addr_b", {59'd0, addr_b}, 64'(l[(2*i+1)*AW +: AW]));
                    chk("R5 lane1", {32'd0, l1}, {32'd0, rf(l[(2*i+1)*AW +: AW])});
                end else begin
                    chk("R6 lane1 zero", {32'd0, l1}, 64'd0);
                end
                chk("R4 stall", {63'd0, stall}, {63'd0, (i != nb - 1)});
                chk("R7 done", {63'd0, done}, {63'd0, (i == nb - 1)});
                if (i == inject) begin
                    start_i = 1'b1; count_i = 4'd0;   // R9: must be ignored
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            check_idle("R3 end");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    end

    initial begin
        int s;
        s = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        chk("R1 en_a", {63'd0, en_a}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");
        chk("R1 lanes", {62'd0, lvld}, 64'd0);

        run_req(40'h12_3456_789A, 0, -1);      // R8
        run_req(40'h00_0000_001F, 0, -1);      // R8 back-to-back
        run_req(40'h00_0000_0013, 1, -1);      // R6 single
        run_req(40'h00_0000_0341, 2, -1);      // R3 one pair
        run_req(40'hAB_CDEF_0123, 7, 1);       // R6, R9
        run_req(40'hFE_DCBA_9876, 8, 0);       // R3 full, R9
        run_req(40'h55_AA55_AA55, 12, -1);     // R10 clamp
        run_req(40'h0F_1E2D_3C4B, 15, 3);      // R10, R9 at last beat

        for (int k = 0; k < 300; k++) begin
            logic [MAXN*AW-1:0] l;
            l = {$urandom, $urandom};
            run_req(l, int'($urandom_range(0, 11)), int'($urandom_range(0, 6)) - 2);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule